// File: doc/BRIEF.md
# Trace Port Word Packer

This block gathers narrow samples from a processor trace port and packs them into 32-bit words ready to be written into a trace RAM. Each sample has three parts: a 3-bit pipeline status, a packet field, and a sync flag. The packet field is 4, 8 or 16 bits wide, depending on the selected port width. A narrower port fits more samples into each stored word. A 4-bit port packs three samples per word, an 8-bit port packs two, and a 16-bit port packs one.

Samples arrive on a valid-qualified input. A completed word leaves on a registered output together with a one-cycle valid strobe and a flag that marks words holding a trigger cycle. A flush input forces out a partly filled word, for example when a capture stops. A change of port width is held off until no partial word is pending, so that one word never mixes two layouts. The port-style input selects normal, multiplexed or demultiplexed operation. Combinations the block cannot pack are reported, and samples are discarded while such a combination is selected. The block does not decode the trace protocol.

Top module: `trace_word_packer`

## Requirements
- R1: After reset, `word_valid_o` and `word_trig_o` are 0, `word_o` is 0, and no partial word is pending.
- R2: With width code 0 (4-bit port), a sample is laid out as status in bits 2:0, packet bits 3:0 in bits 6:3 and sync in bit 7. The first sample of a word takes bits 7:0, the second takes 15:8 and the third takes 23:16. The word is emitted after the third sample.
- R3: With width code 1 (8-bit port), a sample is laid out as status in bits 2:0, packet bits 7:0 in bits 10:3 and sync in bit 11. The first sample takes bits 11:0 and the second takes 23:12. The word is emitted after the second sample.
- R4: With width code 2 (16-bit port), each sample is emitted as its own word: status in bits 2:0, packet in bits 18:3, sync in bit 19, and bits 31:20 zero.
- R5: Packet bits above the selected width are ignored, and word bits 31:24 are always 0.
- R6: Flush behaviour depends on what is pending. If flush is asserted while a partial word is pending, that word is emitted with its empty slots zero. If flush is asserted in the same cycle as an accepted sample, that sample is included before the word is emitted. If flush is asserted with nothing pending and no sample, no word is emitted.
- R7: A change of `mode_i` takes effect only when no partial word is pending. Samples that join a pending word use the width that was in force when that word was started.
- R8: `cfg_err_o` is 1 in any of these cases, and samples are discarded while it is 1:
  - width code 3 is selected;
  - style code 1 (multiplexed) is selected;
  - style code 3 is selected;
  - style code 2 (demultiplexed) is selected with a width code other than 1.
  
  Style code 0 (normal) with width codes 0 to 2 is accepted.
- R9: `word_trig_o` is 1 with an emitted word exactly when at least one sample packed into that word had status 3'b110, the trigger code. The status and packet of such a sample are stored unchanged.
- R10: `word_valid_o` rises one clock after the edge that accepts the completing sample or the flush. It lasts one cycle unless another word completes on the next edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| mode_i | input | 2 | Port width: 0 = 4-bit, 1 = 8-bit, 2 = 16-bit, 3 = reserved |
| style_i | input | 2 | Port style: 0 = normal, 1 = multiplexed, 2 = demultiplexed, 3 = reserved |
| smp_valid_i | input | 1 | Sample present this cycle |
| smp_stat_i | input | 3 | Pipeline status of the sample |
| smp_pkt_i | input | 16 | Packet field; only the low bits for the selected width are used |
| smp_sync_i | input | 1 | Sync flag of the sample |
| flush_i | input | 1 | Emit any pending partial word |
| cfg_err_o | output | 1 | Width and style combination unsupported |
| word_valid_o | output | 1 | Packed word valid strobe |
| word_o | output | 32 | Packed word |
| word_trig_o | output | 1 | Word contains a trigger-status sample |

## Verification
Every result is due on the first clock edge after the stimulus that causes it.

- A packed word, its valid strobe and its trigger flag all come from one register stage. They appear one edge after the completing sample or the flush.
- `cfg_err_o` is combinational and follows the width and style inputs in the same cycle.

The bench drives inputs on the falling edge and lets exactly one rising edge pass. It then samples every output on the next falling edge. This means each check sees the state that follows one edge, and it also confirms that no word appears before its final sample.

// File: rtl/twp_pkg.sv
package twp_pkg;
  typedef enum logic [1:0] {
    MODE_P4  = 2'd0,
    MODE_P8  = 2'd1,
    MODE_P16 = 2'd2,
    MODE_RSV = 2'd3
  } port_mode_e;

  typedef enum logic [1:0] {
    STY_NORMAL = 2'd0,
    STY_MUX    = 2'd1,
    STY_DEMUX  = 2'd2,
    STY_RSV    = 2'd3
  } port_style_e;

  function automatic logic [1:0] slots_per_word(port_mode_e m);
    case (m)
      MODE_P4: return 2'd3;
      MODE_P8: return 2'd2;
      default: return 2'd1;
    endcase
  endfunction

  function automatic logic [4:0] slot_stride(port_mode_e m);
    case (m)
      MODE_P4: return 5'd8;
      MODE_P8: return 5'd12;
      default: return 5'd0;
    endcase
  endfunction
endpackage

// File: rtl/twp_cfg_check.sv
module twp_cfg_check
  import twp_pkg::*;
(
  input  port_mode_e  mode_i,
  input  port_style_e style_i,
  output logic        err_o
);
  always_comb begin
    err_o = 1'b0;
    if (mode_i == MODE_RSV) err_o = 1'b1;
    case (style_i)
      STY_NORMAL: ;
      STY_DEMUX:  if (mode_i != MODE_P8) err_o = 1'b1;
      default:    err_o = 1'b1;
    endcase
  end
endmodule

// File: rtl/twp_slot_fmt.sv
module twp_slot_fmt
  import twp_pkg::*;
#(
  parameter int WORD_W = 32,
  parameter int STAT_W = 3,
  parameter int PKT_W  = 16
) (
  input  port_mode_e        mode_i,
  input  logic [STAT_W-1:0] stat_i,
  input  logic [PKT_W-1:0]  pkt_i,
  input  logic              sync_i,
  output logic [WORD_W-1:0] slot_o
);
  localparam int P4_W  = PKT_W / 4;
  localparam int P8_W  = PKT_W / 2;
  localparam int P16_W = PKT_W;

  logic [WORD_W-1:0] slot_p4, slot_p8, slot_p16;

  // packet truncated to the lane width, sync directly above it
  always_comb begin
    slot_p4  = '0;
    slot_p8  = '0;
    slot_p16 = '0;
    slot_p4[STAT_W-1:0]                 = stat_i;
    slot_p4[STAT_W +: P4_W]             = pkt_i[P4_W-1:0];
    slot_p4[STAT_W+P4_W]                = sync_i;
    slot_p8[STAT_W-1:0]                 = stat_i;
    slot_p8[STAT_W +: P8_W]             = pkt_i[P8_W-1:0];
    slot_p8[STAT_W+P8_W]                = sync_i;
    slot_p16[STAT_W-1:0]                = stat_i;
    slot_p16[STAT_W +: P16_W]           = pkt_i[P16_W-1:0];
    slot_p16[STAT_W+P16_W]              = sync_i;
  end

  always_comb begin
    case (mode_i)
      MODE_P4: slot_o = slot_p4;
      MODE_P8: slot_o = slot_p8;
      default: slot_o = slot_p16;
    endcase
  end
endmodule

// File: rtl/twp_accum.sv
module twp_accum
  import twp_pkg::*;
#(
  parameter int WORD_W = 32,
  parameter int CNT_W  = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  port_mode_e        mode_i,
  input  logic              accept_i,
  input  logic              flush_i,
  input  logic [WORD_W-1:0] slot_i,
  input  logic              trig_i,
  output port_mode_e        eff_mode_o,
  output logic [CNT_W-1:0]  pend_o,
  output logic              word_valid_o,
  output logic [WORD_W-1:0] word_o,
  output logic              word_trig_o
);
  localparam int OFS_W = 6;

  logic [CNT_W-1:0]  cnt_q, cnt_nxt;
  logic [WORD_W-1:0] acc_q, acc_nxt;
  logic              trig_q, trig_nxt;
  port_mode_e        held_q;
  logic [OFS_W-1:0]  ofs;
  logic              full, emit;

  // width latched at the start of each word
  assign eff_mode_o = (cnt_q == '0) ? mode_i : held_q;
  assign pend_o     = cnt_q;

  always_comb begin
    ofs      = OFS_W'(cnt_q) * OFS_W'(slot_stride(eff_mode_o));
    acc_nxt  = acc_q;
    trig_nxt = trig_q;
    cnt_nxt  = cnt_q;
    if (accept_i) begin
      acc_nxt  = acc_q | (slot_i << ofs);
      trig_nxt = trig_q | trig_i;
      cnt_nxt  = cnt_q + 1'b1;
    end
    full = accept_i && (cnt_nxt == CNT_W'(slots_per_word(eff_mode_o)));
    emit = full || (flush_i && (accept_i || (cnt_q != '0)));
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q        <= '0;
      acc_q        <= '0;
      trig_q       <= 1'b0;
      held_q       <= MODE_P4;
      word_valid_o <= 1'b0;
      word_o       <= '0;
      word_trig_o  <= 1'b0;
    end else begin
      word_valid_o <= emit;
      if (cnt_q == '0) held_q <= mode_i;
      if (emit) begin
        word_o      <= acc_nxt;
        word_trig_o <= trig_nxt;
        acc_q       <= '0;
        trig_q      <= 1'b0;
        cnt_q       <= '0;
      end else begin
        acc_q  <= acc_nxt;
        trig_q <= trig_nxt;
        cnt_q  <= cnt_nxt;
      end
    end
  end
endmodule

// File: rtl/trace_word_packer.sv
module trace_word_packer
  import twp_pkg::*;
#(
  parameter int          WORD_W    = 32,
  parameter int          STAT_W    = 3,
  parameter int          PKT_W     = 16,
  parameter logic [2:0]  TRIG_CODE = 3'b110
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [1:0]        mode_i,
  input  logic [1:0]        style_i,
  input  logic              smp_valid_i,
  input  logic [STAT_W-1:0] smp_stat_i,
  input  logic [PKT_W-1:0]  smp_pkt_i,
  input  logic              smp_sync_i,
  input  logic              flush_i,
  output logic              cfg_err_o,
  output logic              word_valid_o,
  output logic [WORD_W-1:0] word_o,
  output logic              word_trig_o
);
  localparam int CNT_W = 2;

  port_mode_e        eff_mode;
  logic [CNT_W-1:0]  pend_cnt;
  logic [WORD_W-1:0] slot;
  logic              accept;
  logic              is_trig;

  twp_cfg_check u_cfg (
    .mode_i  (port_mode_e'(mode_i)),
    .style_i (port_style_e'(style_i)),
    .err_o   (cfg_err_o)
  );

  twp_slot_fmt #(.WORD_W(WORD_W), .STAT_W(STAT_W), .PKT_W(PKT_W)) u_fmt (
    .mode_i (eff_mode),
    .stat_i (smp_stat_i),
    .pkt_i  (smp_pkt_i),
    .sync_i (smp_sync_i),
    .slot_o (slot)
  );

  assign accept  = smp_valid_i && !cfg_err_o;
  assign is_trig = (smp_stat_i == TRIG_CODE);

  twp_accum #(.WORD_W(WORD_W), .CNT_W(CNT_W)) u_acc (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .mode_i       (port_mode_e'(mode_i)),
    .accept_i     (accept),
    .flush_i      (flush_i),
    .slot_i       (slot),
    .trig_i       (is_trig),
    .eff_mode_o   (eff_mode),
    .pend_o       (pend_cnt),
    .word_valid_o (word_valid_o),
    .word_o       (word_o),
    .word_trig_o  (word_trig_o)
  );
endmodule

// File: rtl/twp_checker.sv
module twp_checker #(
  parameter int WORD_W = 32
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              smp_valid_i,
  input logic              flush_i,
  input logic              cfg_err_o,
  input logic              word_valid_o,
  input logic [WORD_W-1:0] word_o,
  input logic [1:0]        pend_i,
  input logic [1:0]        eff_mode_i
);
  // R5
  a_r5_upper_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    word_valid_o |-> (word_o[WORD_W-1:24] == '0));

  // R8
  a_r8_err_drops: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cfg_err_o && !flush_i) |=> !word_valid_o);

  // R6
  a_r6_empty_flush: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (flush_i && !smp_valid_i && pend_i == 2'd0) |=> !word_valid_o);

  // R10
  a_r10_cause: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!flush_i && !(smp_valid_i && !cfg_err_o)) |=> !word_valid_o);

  // R7
  a_r7_mode_held: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pend_i != 2'd0) |-> (eff_mode_i == $past(eff_mode_i)));

  // R1
  a_r1_reset_clean: assert property (@(posedge clk_i)
    $rose(rst_ni) |-> (!word_valid_o && pend_i == 2'd0));
endmodule

bind trace_word_packer twp_checker #(.WORD_W(WORD_W)) i_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .smp_valid_i  (smp_valid_i),
  .flush_i      (flush_i),
  .cfg_err_o    (cfg_err_o),
  .word_valid_o (word_valid_o),
  .word_o       (word_o),
  .pend_i       (pend_cnt),
  .eff_mode_i   (eff_mode)
);

// File: tb/test_trace_word_packer.sv
module test_trace_word_packer;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic [1:0]  mode_i = 2'd0;
  logic [1:0]  style_i = 2'd0;
  logic        smp_valid_i = 1'b0;
  logic [2:0]  smp_stat_i = '0;
  logic [15:0] smp_pkt_i = '0;
  logic        smp_sync_i = 1'b0;
  logic        flush_i = 1'b0;
  logic        cfg_err_o;
  logic        word_valid_o;
  logic [31:0] word_o;
  logic        word_trig_o;

  int nvec = 0;
  int nfail = 0;

  always #5 clk_i = ~clk_i;

  trace_word_packer i_trace_word_packer (.*);

  function automatic logic [31:0] f4(logic [2:0] s, logic [15:0] p, logic y);
    return {24'd0, y, p[3:0], s};
  endfunction
  function automatic logic [31:0] f8(logic [2:0] s, logic [15:0] p, logic y);
    return {20'd0, y, p[7:0], s};
  endfunction
  function automatic logic [31:0] f16(logic [2:0] s, logic [15:0] p, logic y);
    return {12'd0, y, p, s};
  endfunction

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    nvec++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // at a falling edge: drive, pass one rising edge, return at next falling edge
  task automatic push(logic v, logic [2:0] s, logic [15:0] p, logic y, logic fl);
    smp_valid_i = v; smp_stat_i = s; smp_pkt_i = p; smp_sync_i = y; flush_i = fl;
    @(negedge clk_i);
    smp_valid_i = 1'b0; flush_i = 1'b0;
  endtask

  task automatic t_reset();
    check("R1 valid", 32'(word_valid_o), 0);
    check("R1 word", word_o, 0);
    check("R1 trig", 32'(word_trig_o), 0);
    push(0, 0, 0, 0, 1);
    check("R1 nothing pending", 32'(word_valid_o), 0);
  endtask

  task automatic t_p4();
    mode_i = 2'd0;
    push(1, 3'd1, 16'hFFFA, 1, 0);
    check("R2 no early word 1", 32'(word_valid_o), 0);
    push(1, 3'd2, 16'h0005, 0, 0);
    check("R2 no early word 2", 32'(word_valid_o), 0);
    push(1, 3'd7, 16'h123F, 1, 0);
    check("R10 valid after 3rd", 32'(word_valid_o), 1);
    check("R2 R5 layout", word_o,
          f4(1, 16'hFFFA, 1) | (f4(2, 16'h0005, 0) << 8) | (f4(7, 16'h123F, 1) << 16));
    push(0, 0, 0, 0, 0);
    check("R10 single pulse", 32'(word_valid_o), 0);
  endtask

  task automatic t_p8();
    mode_i = 2'd1;
    push(1, 3'd3, 16'hAB5C, 1, 0);
    check("R3 no early word", 32'(word_valid_o), 0);
    push(1, 3'd4, 16'h77E1, 0, 0);
    check("R3 valid", 32'(word_valid_o), 1);
    check("R3 layout", word_o, f8(3, 16'hAB5C, 1) | (f8(4, 16'h77E1, 0) << 12));
  endtask

  task automatic t_p16();
    mode_i = 2'd2;
    push(1, 3'd5, 16'hBEEF, 1, 0);
    check("R4 valid", 32'(word_valid_o), 1);
    check("R4 layout", word_o, f16(5, 16'hBEEF, 1));
    push(1, 3'd2, 16'h0001, 0, 0);
    check("R10 back-to-back", 32'(word_valid_o), 1);
    check("R4 second word", word_o, f16(2, 16'h0001, 0));
  endtask

  task automatic t_flush();
    mode_i = 2'd0;
    push(1, 3'd6, 16'h0009, 1, 0);
    push(0, 0, 0, 0, 1);
    check("R6 partial emitted", 32'(word_valid_o), 1);
    check("R6 partial zeroed", word_o, f4(6, 16'h0009, 1));
    push(0, 0, 0, 0, 1);
    check("R6 empty flush", 32'(word_valid_o), 0);
    mode_i = 2'd1;
    push(1, 3'd1, 16'h0042, 0, 1);
    check("R6 flush with sample", 32'(word_valid_o), 1);
    check("R6 flush with sample word", word_o, f8(1, 16'h0042, 0));
  endtask

  task automatic t_mode_defer();
    mode_i = 2'd0;
    push(1, 3'd1, 16'h0003, 0, 0);
    mode_i = 2'd2;
    push(1, 3'd2, 16'hFFF4, 1, 0);
    check("R7 no word after mode change", 32'(word_valid_o), 0);
    push(1, 3'd3, 16'h0005, 0, 0);
    check("R7 word done", 32'(word_valid_o), 1);
    check("R7 old layout kept", word_o,
          f4(1, 16'h0003, 0) | (f4(2, 16'hFFF4, 1) << 8) | (f4(3, 16'h0005, 0) << 16));
    push(1, 3'd4, 16'hC0DE, 1, 0);
    check("R7 new mode applies", word_o, f16(4, 16'hC0DE, 1));
  endtask

  task automatic t_cfg();
    mode_i = 2'd3; style_i = 2'd0; #1;
    check("R8 reserved width", 32'(cfg_err_o), 1);
    mode_i = 2'd1; style_i = 2'd1; #1;
    check("R8 multiplexed", 32'(cfg_err_o), 1);
    style_i = 2'd2; #1;
    check("R8 demux 8-bit ok", 32'(cfg_err_o), 0);
    mode_i = 2'd0; #1;
    check("R8 demux 4-bit", 32'(cfg_err_o), 1);
    mode_i = 2'd2; #1;
    check("R8 demux 16-bit", 32'(cfg_err_o), 1);
    push(1, 3'd1, 16'h1111, 1, 0);
    check("R8 sample dropped", 32'(word_valid_o), 0);
    style_i = 2'd0; mode_i = 2'd2;
    push(0, 0, 0, 0, 1);
    check("R8 nothing left pending", 32'(word_valid_o), 0);
    push(1, 3'd0, 16'h2222, 0, 0);
    check("R8 recovered", word_o, f16(0, 16'h2222, 0));
  endtask

  task automatic t_trig();
    mode_i = 2'd1;
    push(1, 3'b110, 16'h0003, 0, 0);
    push(1, 3'd2, 16'h0010, 1, 0);
    check("R9 trig flag", 32'(word_trig_o), 1);
    check("R9 stored unchanged", word_o, f8(6, 16'h0003, 0) | (f8(2, 16'h0010, 1) << 12));
    push(1, 3'd1, 16'h0, 0, 0);
    push(1, 3'd7, 16'h0, 0, 0);
    check("R9 no trig", 32'(word_trig_o), 0);
  endtask

  initial begin
    repeat (100000) @(posedge clk_i);
    nfail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", nvec, nfail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);
    t_reset();
    t_p4();
    t_p8();
    t_p16();
    t_flush();
    t_mode_defer();
    t_cfg();
    t_trig();
    $display("== %0d vectors applied, %0d miscompares ==", nvec, nfail);
    $finish;
  end
endmodule